// File: doc/BRIEF.md
# Six-Step Accumulator Processor with Return-Address Store

This block is a small accumulator processor. A single 16-word by 8-bit memory holds both the program and its data. An 8-bit accumulator and a B operand register carry out the arithmetic. A 4-bit program counter walks through the program. An 8-bit output register publishes results, and a halted flag reports the end of execution.

Every instruction takes six steps, driven by a one-hot ring sequencer. The first three steps are a fetch that is the same for every instruction. The last three steps decode and execute the opcode.

Besides load, add, subtract, output and halt, the processor has a save-PC instruction. It writes the already-incremented program counter, zero-extended to 8 bits, into the memory word named by its address field. A program-load port fills the memory before execution starts. While that port is active, the sequencer stays frozen.

Top module: `accu_core`

## Requirements
- R1: While reset is held, the core drives outReg = 0x00 and halted = 0. Reset clears the program counter, the accumulator and the step sequencer, so execution starts at address 0.
- R2: In each instruction byte, bits 7:4 hold the opcode and bits 3:0 hold a memory address. The opcodes are 0x0 load, 0x1 add, 0x2 subtract, 0x3 save-PC, 0xE output and 0xF halt.
- R3: Load copies a memory word into the accumulator. Add and subtract first copy the word into B, then write acc+B or acc-B modulo 256 back to the accumulator. Output copies the accumulator to outReg. The program {0x0C, 0x1D, 0x2E, 0xE0, 0xF0}, with 0x0C, 0x09 and 0x05 at addresses 12, 13 and 14, outputs 0x10.
- R4: Every instruction takes exactly six clock edges. The first three are fetch: address from PC, PC increment, instruction load. A halt at instruction index k raises halted after edge 6k+4, counted from the first edge on which the core runs.
- R5: Once halted is set, it stays set until reset. The sequencer and outReg stay unchanged while it is set.
- R6: Save-PC writes {0000, PC} into the memory word at its address field. The PC value is the address of the next instruction. The write happens in the fifth step and overwrites all eight bits of the word.
- R7: Any opcode other than the six listed is a no-op. It changes neither the accumulator nor the memory, but it still takes six edges.
- R8: When loadEn is 1, loadData is written to memory[loadAddr] on the clock edge, and the sequencer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Program-load write enable; freezes the sequencer |
| loadAddr | input | 4 | Program-load word address |
| loadData | input | 8 | Program-load word data |
| outReg | output | 8 | Output register |
| halted | output | 1 | Set by the halt instruction until reset |

## Verification
The embedded properties check the following on every cycle:
- The sequencer stays one-hot.
- The halted flag is sticky, and the step does not move while the core is halted or loading.
- A save-PC write leaves a zero upper nibble and the current PC in the lower one.

Only the scenarios can show the rest:
- The arithmetic results with wraparound.
- The exact six-edge instruction timing up to the halt.
- That unknown opcodes leave the accumulator and the memory untouched.
- That a stored return address reads back through a later load and output.

// File: rtl/accu_pkg.sv
package accu_pkg;

  // Number of one-hot sequencer steps per instruction
  localparam int STEP_N = 6;

  typedef enum logic [3:0] {
    OP_LOAD   = 4'h0,
    OP_ADD    = 4'h1,
    OP_SUB    = 4'h2,
    OP_SAVEPC = 4'h3,
    OP_OUT    = 4'hE,
    OP_HALT   = 4'hF
  } opcode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic marFromPc;
    logic pcInc;
    logic irLoad;
    logic marFromIr;
    logic accFromMem;
    logic bFromMem;
    logic accAdd;
    logic accSub;
    logic outFromAcc;
    logic memStorePc;
  } ctrl_strobes_t;

endpackage

// File: rtl/accu_ctrl.sv
module accu_ctrl
  import accu_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            freeze,
  input  logic [OP_W-1:0] opcode,
  output ctrl_strobes_t   strb,
  output logic            halted
);

  logic [STEP_N-1:0] ring;
  logic              haltNow;

  // Step decode
  always_comb begin
    strb    = '0;
    haltNow = 1'b0;
    if (!halted && !freeze) begin
      if (ring[0]) strb.marFromPc = 1'b1;
      if (ring[1]) strb.pcInc     = 1'b1;
      if (ring[2]) strb.irLoad    = 1'b1;
      if (ring[3]) begin
        case (opcode)
          OP_LOAD, OP_ADD, OP_SUB, OP_SAVEPC: strb.marFromIr = 1'b1;
          OP_OUT:  strb.outFromAcc = 1'b1;
          OP_HALT: haltNow = 1'b1;
          default: ;
        endcase
      end
      if (ring[4]) begin
        case (opcode)
          OP_LOAD:         strb.accFromMem = 1'b1;
          OP_ADD, OP_SUB:  strb.bFromMem   = 1'b1;
          OP_SAVEPC:       strb.memStorePc = 1'b1;
          default: ;
        endcase
      end
      if (ring[5]) begin
        case (opcode)
          OP_ADD:  strb.accAdd = 1'b1;
          OP_SUB:  strb.accSub = 1'b1;
          default: ;
        endcase
      end
    end
  end

  // Ring sequencer and halt flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ring   <= {{(STEP_N-1){1'b0}}, 1'b1};
      halted <= 1'b0;
    end else if (!freeze && !halted) begin
      if (haltNow) halted <= 1'b1;
      else         ring   <= {ring[STEP_N-2:0], ring[STEP_N-1]};
    end
  end

  AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $countones(ring) == 1); // R4
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN) halted |=> halted); // R5
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rstN) halted |=> $stable(ring)); // R5
  AST_LOAD_FROZEN: assert property (@(posedge clk) disable iff (!rstN) freeze |=> $stable(ring)); // R8

endmodule

// File: rtl/accu_datapath.sv
module accu_datapath
  import accu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_strobes_t            strb,
  input  logic                     loadEn,
  input  logic [ADDR_W-1:0]        loadAddr,
  input  logic [DATA_W-1:0]        loadData,
  output logic [DATA_W-ADDR_W-1:0] opcode,
  output logic [DATA_W-1:0]        outReg
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int OP_W  = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] bReg;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] memRd;
  logic [DATA_W-1:0] pcExt;

  assign memRd  = mem[mar];
  assign pcExt  = {{OP_W{1'b0}}, pc};
  assign opcode = ir[DATA_W-1:ADDR_W];

  // Registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= '0;
      mar    <= '0;
      ir     <= '0;
      acc    <= '0;
      bReg   <= '0;
      outReg <= '0;
    end else begin
      if (strb.marFromPc)  mar    <= pc;
      if (strb.marFromIr)  mar    <= ir[ADDR_W-1:0];
      if (strb.pcInc)      pc     <= pc + 1'b1;
      if (strb.irLoad)     ir     <= memRd;
      if (strb.bFromMem)   bReg   <= memRd;
      if (strb.accFromMem) acc    <= memRd;
      if (strb.accAdd)     acc    <= acc + bReg;
      if (strb.accSub)     acc    <= acc - bReg;
      if (strb.outFromAcc) outReg <= acc;
    end
  end

  // Memory: load port has priority, then the return-address store
  always_ff @(posedge clk) begin
    if (loadEn)               mem[loadAddr] <= loadData;
    else if (strb.memStorePc) mem[mar]      <= pcExt;
  end

  AST_STORE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memStorePc && !loadEn) |=> mem[$past(mar)][DATA_W-1:ADDR_W] == '0); // R6
  AST_STORE_PC_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memStorePc && !loadEn) |=> mem[$past(mar)][ADDR_W-1:0] == pc); // R6
  AST_FETCH_INC: assert property (@(posedge clk) disable iff (!rstN)
    strb.pcInc |=> pc == $past(pc) + 1'b1); // R4

endmodule

// File: rtl/accu_core.sv
module accu_core
  import accu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] outReg,
  output logic              halted
);

  localparam int OP_W = DATA_W - ADDR_W;

  ctrl_strobes_t   strb;
  logic [OP_W-1:0] opcode;

  accu_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .freeze (loadEn),
    .opcode (opcode),
    .strb   (strb),
    .halted (halted)
  );

  accu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .opcode   (opcode),
    .outReg   (outReg)
  );

  AST_HALT_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> $stable(outReg)); // R5

endmodule

// File: tb/accu_core_tb.sv
`timescale 1ns/1ps
module accu_core_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadEn = 1'b0;
  logic [3:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic [7:0] outReg;
  logic       halted;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [7:0] prog [16];
  logic [7:0] expQ [$];
  logic [7:0] prevOut = '0;

  always #4 clk = ~clk;

  accu_core u_dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .outReg(outReg), .halted(halted)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard
  task automatic expectOut(input logic [7:0] v);
    expQ.push_back(v);
  endtask

  // Monitor: each new value on outReg is compared with the next expected item
  always @(negedge clk) begin
    if (rstN && outReg != prevOut) begin
      if (expQ.size() == 0) check(1'b0, "R3 unexpected output", outReg, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(outReg == e, "R3 output value", outReg, e);
      end
    end
    prevOut = outReg;
  end

  // Global watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic clearProg();
    for (int i = 0; i < 16; i++) prog[i] = 8'h00;
  endtask

  // Load the program in reset, optionally hold loadEn after reset, then run to halt
  task automatic runProg(input int haltIdx, input int hold, input string tag);
    int count;
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      loadEn = 1'b1;
      loadAddr = 4'(i);
      loadData = prog[i];
    end
    @(negedge clk);
    loadEn = 1'b0;
    check(outReg == 8'h00 && halted == 1'b0, "R1 reset state", {halted, outReg}, 0);
    rstN = 1'b1;
    if (hold > 0) begin
      loadEn = 1'b1;
      loadAddr = 4'hF;
      loadData = prog[15];
      repeat (hold) @(negedge clk);
      loadEn = 1'b0;
    end
    count = 0;
    while (1) begin
      @(posedge clk);
      count++;
      @(negedge clk);
      if (halted) break;
      if (count > 400) break;
    end
    check(count == 6 * haltIdx + 4, {"R4 halt edge count ", tag}, count, 6 * haltIdx + 4);
    check(expQ.size() == 0, {"R3 all outputs seen ", tag}, expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    // P1: reference arithmetic program (R2, R3)
    clearProg();
    prog[0] = 8'h0C; prog[1] = 8'h1D; prog[2] = 8'h2E; prog[3] = 8'hE0; prog[4] = 8'hF0;
    prog[12] = 8'h0C; prog[13] = 8'h09; prog[14] = 8'h05;
    expectOut(8'h10);
    runProg(4, 0, "p1");
    // R5: halt is sticky, output frozen
    repeat (30) @(negedge clk);
    check(halted == 1'b1, "R5 halted sticky", halted, 1);
    check(outReg == 8'h10, "R5 output held", outReg, 8'h10);

    // P2: wraparound in both directions, run start delayed by the load port (R3, R8)
    clearProg();
    prog[0] = 8'h0A; prog[1] = 8'h1B; prog[2] = 8'hE0; prog[3] = 8'h2C; prog[4] = 8'hE0; prog[5] = 8'hF0;
    prog[10] = 8'hF0; prog[11] = 8'h20; prog[12] = 8'h30;
    expectOut(8'h10);
    expectOut(8'hE0);
    runProg(5, 12, "p2 R8 frozen during load");

    // P3: save-PC stores next address, zero upper nibble (R6)
    clearProg();
    prog[0] = 8'h3E; prog[1] = 8'h0E; prog[2] = 8'hE0; prog[3] = 8'h3D;
    prog[4] = 8'h1D; prog[5] = 8'hE0; prog[6] = 8'hF0;
    prog[13] = 8'hFF; prog[14] = 8'hAB;
    expectOut(8'h01);
    expectOut(8'h05);
    runProg(6, 0, "p3 R6");

    // P4: unknown opcodes are no-ops (R7)
    clearProg();
    prog[0] = 8'h0F; prog[1] = 8'h5F; prog[2] = 8'h9F; prog[3] = 8'hE0;
    prog[4] = 8'h6E; prog[5] = 8'h1E; prog[6] = 8'hE0; prog[7] = 8'hF0;
    prog[14] = 8'h33; prog[15] = 8'h42;
    expectOut(8'h42);
    expectOut(8'h75);
    runProg(7, 0, "p4 R7");

    // P5: halt as the first instruction, output untouched (R4, R5)
    clearProg();
    prog[0] = 8'hF0;
    runProg(0, 0, "p5");
    repeat (10) @(negedge clk);
    check(outReg == 8'h00 && halted, "R5 immediate halt", {halted, outReg}, 9'h100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule